// File: doc/BRIEF.md
# Stack-Machine Jump and PC Sequencer

This block steers the program counter of a byte-addressed stack machine. The code stream is variable length: most opcodes take one byte, but a push opcode carries up to 32 inline data bytes that must never be fetched as opcodes. The block reads one code byte per cycle from a combinational code memory port and emits a strobe for every instruction it steps over, together with that instruction's byte address. It does not execute arithmetic or memory opcodes and holds no stack. For the two control-transfer opcodes it requests stack items through a pop handshake: the unconditional jump consumes one item (the target), the conditional jump consumes the target and then the condition.

After reset the block first walks the whole program along instruction boundaries and records in a bitmap every destination-marker opcode it meets as a real opcode. Marker bytes that lie inside push data are never recorded. Execution then starts at address 0. A jump lands only on a recorded marker that lies below the code length; any other target halts the sequencer with a fault. A stop opcode, or running off the end of the code, halts it with a stop. Both halted conditions hold until the next reset.

Top module: `jump_pc_sequencer`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and stop_o, fault_o, insn_valid_o and pop_req_o are all 0.
- R2: Every executed instruction gives exactly one cycle of insn_valid_o with pc_o equal to its byte address, in execution order; an opcode that is not a push (0x60..0x7F), jump (0x56), conditional jump (0x57) or stop (0x00) advances the PC by 1.
- R3: A push opcode 0x60..0x7F carries n = opcode - 0x5F inline bytes and advances the PC by 1 + n; the inline bytes never raise insn_valid_o.
- R4: The jump opcode 0x56 pops exactly one stack item and, if it is a valid destination, continues at that address.
- R5: The conditional jump opcode 0x57 pops the destination first and the condition second; a condition with any bit set takes the jump, a condition of zero continues at the next byte.
- R6: A valid destination holds the marker opcode 0x5B reached as an opcode along instruction boundaries from address 0; a target inside push data, or on any other opcode, raises fault_o.
- R7: A target at or above the code length, including any target with bits set above the address width, raises fault_o.
- R8: The stop opcode 0x00 raises stop_o with pc_o left on it; reaching an address at or past code_len_i (also by a push that runs past the end) raises stop_o with pc_o equal to code_len_i.
- R9: stop_o and fault_o are never both set and stay set until reset; while either is set, insn_valid_o and pop_req_o stay low and pc_o keeps the address of the halting instruction.
- R10: pop_req_o stays high with pc_o unchanged and no instruction strobe until pop_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; starts the destination scan when released |
| code_len_i | input | AW+1 | Program length in bytes, at most MAX_CODE |
| code_addr_o | output | AW | Code memory read address |
| code_byte_i | input | 8 | Code byte at code_addr_o, same cycle |
| pop_req_o | output | 1 | Request for the next stack item |
| pop_ack_i | input | 1 | Stack item on pop_data_i is consumed this cycle |
| pop_data_i | input | WORD_W | Popped stack item |
| pc_o | output | AW+1 | Program counter (byte address) |
| insn_valid_o | output | 1 | One-cycle strobe per executed instruction |
| stop_o | output | 1 | Sticky normal halt |
| fault_o | output | 1 | Sticky halt on an invalid jump target |

## Verification
The assertions take for granted that code_len_i is stable from reset release to the halt and no larger than MAX_CODE, that code_byte_i is the byte at code_addr_o in the same cycle, and that pop_data_i is valid whenever pop_ack_i is high. The bench loads each program and its length while reset is held, models the code memory combinationally from code_addr_o, and answers pop requests only from a prepared stack queue, with an optional delay of several cycles before each acknowledge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam logic [7:0] OP_STOP  = 8'h00;
  localparam logic [7:0] OP_JUMP  = 8'h56;
  localparam logic [7:0] OP_JUMPI = 8'h57;
  localparam logic [7:0] OP_MARK  = 8'h5B;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_FETCH,
    ST_POP_DST,
    ST_POP_CND,
    ST_STOP,
    ST_FAULT
  } seq_state_e;

  function automatic logic is_push(input logic [7:0] op);
    return op[7:5] == 3'b011;
  endfunction

  // opcode byte plus inline data bytes
  function automatic logic [5:0] insn_len(input logic [7:0] op);
    return is_push(op) ? (6'(op[4:0]) + 6'd2) : 6'd1;
  endfunction

endpackage

// File: rtl/pcs_step.sv
module pcs_step #(
  parameter int PCW = 9
) (
  input  logic [PCW-1:0] cur_i,
  input  logic [7:0]     op_i,
  input  logic [PCW-1:0] len_i,
  output logic [PCW-1:0] nxt_o
);
  import pcs_pkg::*;

  localparam int NW = PCW + 6;

  logic [NW-1:0] wide;

  always_comb begin
    wide = NW'(cur_i) + NW'(insn_len(op_i));
    // clamp at the code end so a trailing push cannot wrap
    nxt_o = (wide >= NW'(len_i)) ? len_i : wide[PCW-1:0];
  end

endmodule

// File: rtl/pcs_dest_map.sv
module pcs_dest_map #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PCW   = 9,
  parameter int WW    = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_i,
  input  logic [AW-1:0]  set_addr_i,
  input  logic [WW-1:0]  tgt_i,
  input  logic [PCW-1:0] len_i,
  output logic           ok_o
);

  localparam int CW = (WW > PCW) ? WW : PCW;

  logic [DEPTH-1:0] map_q;
  logic             in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    map_q <= '0;
    else if (set_i) map_q[set_addr_i] <= 1'b1;
  end

  always_comb begin
    in_range = CW'(tgt_i) < CW'(len_i);
    ok_o     = in_range && map_q[tgt_i[AW-1:0]];
  end

endmodule

// File: rtl/jump_pc_sequencer.sv
module jump_pc_sequencer #(
  parameter int MAX_CODE = 256,
  parameter int WORD_W   = 32,
  localparam int AW      = $clog2(MAX_CODE),
  localparam int PCW     = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PCW-1:0]    code_len_i,
  output logic [AW-1:0]     code_addr_o,
  input  logic [7:0]        code_byte_i,
  output logic              pop_req_o,
  input  logic              pop_ack_i,
  input  logic [WORD_W-1:0] pop_data_i,
  output logic [PCW-1:0]    pc_o,
  output logic              insn_valid_o,
  output logic              stop_o,
  output logic              fault_o
);
  import pcs_pkg::*;

  seq_state_e        st_q;
  logic [PCW-1:0]    ptr_q;
  logic [WORD_W-1:0] dst_q;
  logic              cond_q;

  logic [PCW-1:0]    ptr_nxt;
  logic              at_end;
  logic              mark_set;
  logic [WORD_W-1:0] tgt;
  logic              tgt_ok;

  assign at_end      = ptr_q >= code_len_i;
  assign code_addr_o = ptr_q[AW-1:0];
  assign mark_set    = (st_q == ST_SCAN) && !at_end && (code_byte_i == OP_MARK);
  assign tgt         = (st_q == ST_POP_DST) ? pop_data_i : dst_q;

  // one stepper serves both the scan pass and execution
  pcs_step #(.PCW(PCW)) u_step (
    .cur_i (ptr_q),
    .op_i  (code_byte_i),
    .len_i (code_len_i),
    .nxt_o (ptr_nxt)
  );

  pcs_dest_map #(
    .DEPTH (MAX_CODE),
    .AW    (AW),
    .PCW   (PCW),
    .WW    (WORD_W)
  ) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (mark_set),
    .set_addr_i (ptr_q[AW-1:0]),
    .tgt_i      (tgt),
    .len_i      (code_len_i),
    .ok_o       (tgt_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SCAN;
      ptr_q  <= '0;
      dst_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_SCAN: begin
          if (at_end) begin
            st_q  <= ST_FETCH;
            ptr_q <= '0;
          end else begin
            ptr_q <= ptr_nxt;
          end
        end
        ST_FETCH: begin
          if (at_end || code_byte_i == OP_STOP) begin
            st_q <= ST_STOP;
          end else if (code_byte_i == OP_JUMP || code_byte_i == OP_JUMPI) begin
            st_q   <= ST_POP_DST;
            cond_q <= (code_byte_i == OP_JUMPI);
          end else begin
            ptr_q <= ptr_nxt;
          end
        end
        ST_POP_DST: begin
          if (pop_ack_i) begin
            dst_q <= pop_data_i;
            if (cond_q) begin
              st_q <= ST_POP_CND;
            end else if (tgt_ok) begin
              st_q  <= ST_FETCH;
              ptr_q <= PCW'(pop_data_i);
            end else begin
              st_q <= ST_FAULT;
            end
          end
        end
        ST_POP_CND: begin
          if (pop_ack_i) begin
            if (!(|pop_data_i)) begin
              st_q  <= ST_FETCH;
              ptr_q <= ptr_nxt;
            end else if (tgt_ok) begin
              st_q  <= ST_FETCH;
              ptr_q <= PCW'(dst_q);
            end else begin
              st_q <= ST_FAULT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign pc_o         = (st_q == ST_SCAN) ? '0 : ptr_q;
  assign insn_valid_o = (st_q == ST_FETCH) && !at_end;
  assign pop_req_o    = (st_q == ST_POP_DST) || (st_q == ST_POP_CND);
  assign stop_o       = (st_q == ST_STOP);
  assign fault_o      = (st_q == ST_FAULT);

  AST_PC_IN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o |-> pc_o < code_len_i); // R2

  AST_PLAIN_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o && !is_push(code_byte_i) && code_byte_i != OP_STOP &&
    code_byte_i != OP_JUMP && code_byte_i != OP_JUMPI
    |=> pc_o == $past(pc_o) + 1'b1); // R2

  AST_PUSH_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o && is_push(code_byte_i) |=> pc_o > $past(pc_o)); // R3

  AST_HALT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_o && fault_o)); // R9

  AST_STOP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> stop_o && $stable(pc_o)); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o && $stable(pc_o)); // R9

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o || fault_o) |-> !insn_valid_o && !pop_req_o); // R9

  AST_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_o && !pop_ack_i |=> pop_req_o && $stable(pc_o) && !insn_valid_o); // R10

endmodule

// File: tb/jump_pc_sequencer_bench.sv
module jump_pc_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CODE   = 256;
  localparam int WORD_W     = 32;
  localparam int AW         = $clog2(MAX_CODE);
  localparam int PCW        = AW + 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [PCW-1:0]    code_len_i = '0;
  logic [AW-1:0]     code_addr_o;
  logic [7:0]        code_byte_i;
  logic              pop_req_o;
  logic              pop_ack_i = 1'b0;
  logic [WORD_W-1:0] pop_data_i = '0;
  logic [PCW-1:0]    pc_o;
  logic              insn_valid_o;
  logic              stop_o;
  logic              fault_o;

  logic [7:0]        mem [MAX_CODE];
  logic [7:0]        code_q [$];
  logic [WORD_W-1:0] stk_q [$];
  int                exp_q [$];
  int                n_cmp = 0;
  int                n_bad = 0;
  int                ack_dly = 0;
  int                wait_cnt = 0;
  int                stall_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb code_byte_i = mem[code_addr_o];

  jump_pc_sequencer #(.MAX_CODE(MAX_CODE), .WORD_W(WORD_W)) u_jump_pc_sequencer (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .code_len_i   (code_len_i),
    .code_addr_o  (code_addr_o),
    .code_byte_i  (code_byte_i),
    .pop_req_o    (pop_req_o),
    .pop_ack_i    (pop_ack_i),
    .pop_data_i   (pop_data_i),
    .pc_o         (pc_o),
    .insn_valid_o (insn_valid_o),
    .stop_o       (stop_o),
    .fault_o      (fault_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected PCs as strobes appear
  always @(negedge clk) begin
    if (rst_ni && insn_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected strobe, pc", longint'(pc_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(pc_o) == e, "R2/R3 strobe pc", longint'(pc_o), e);
      end
    end
  end

  // stack responder with optional acknowledge delay
  always @(negedge clk) begin
    if (!rst_ni) begin
      pop_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (pop_ack_i) begin
      void'(stk_q.pop_front());
      pop_ack_i = 1'b0;
    end else if (pop_req_o && stk_q.size() > 0) begin
      if (wait_cnt < ack_dly) begin
        wait_cnt++;
        stall_cnt++;
      end else begin
        pop_ack_i  = 1'b1;
        pop_data_i = stk_q[0];
        wait_cnt   = 0;
      end
    end
  end

  task automatic run(input string tag, input bit e_stop, input bit e_fault, input int e_pc);
    int cyc;
    rst_ni = 1'b0;
    foreach (mem[i]) mem[i] = 8'hFE;
    foreach (code_q[i]) mem[i] = code_q[i];
    code_len_i = PCW'(code_q.size());
    repeat (2) @(negedge clk);
    chk(pc_o == 0 && !stop_o && !fault_o && !insn_valid_o && !pop_req_o,
        {tag, " R1 reset outputs"}, {pc_o, stop_o, fault_o, insn_valid_o, pop_req_o}, 0);
    rst_ni = 1'b1;
    cyc = 0;
    while (!(stop_o || fault_o) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (6) @(negedge clk);
    chk(stop_o == e_stop, {tag, " R8 stop_o"}, stop_o, e_stop);
    chk(fault_o == e_fault, {tag, " R6/R7 fault_o"}, fault_o, e_fault);
    chk(int'(pc_o) == e_pc, {tag, " R9 halted pc_o"}, pc_o, e_pc);
    chk(!insn_valid_o && !pop_req_o, {tag, " R9 quiet when halted"},
        {insn_valid_o, pop_req_o}, 0);
    chk(exp_q.size() == 0, {tag, " R2 missing strobes"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R2 R8: straight line to stop
    code_q = '{8'h01, 8'h02, 8'h00};
    stk_q = {}; exp_q = '{0, 1, 2};
    run("linear", 1'b1, 1'b0, 2);

    // R3: push widths 1, 2, 32; markers inside data are not opcodes
    code_q = '{8'h60, 8'hAA, 8'h61, 8'hBB, 8'hCC, 8'h7F};
    for (int i = 0; i < 32; i++) code_q.push_back(8'h5B);
    code_q.push_back(8'h00);
    stk_q = {}; exp_q = '{0, 2, 5, 38};
    run("push skip", 1'b1, 1'b0, 38);

    // R4: jump pops one item, lands on marker
    code_q = '{8'h56, 8'h01, 8'h5B, 8'h00};
    stk_q = '{32'd2, 32'd99}; exp_q = '{0, 2, 3};
    run("jump", 1'b1, 1'b0, 3);
    chk(stk_q.size() == 1, "R4 jump pops exactly one", stk_q.size(), 1);

    // R5: taken, condition with only the top bit set
    code_q = '{8'h57, 8'h00, 8'h5B, 8'h00};
    stk_q = '{32'd2, 32'h8000_0000}; exp_q = '{0, 2, 3};
    run("jumpi taken", 1'b1, 1'b0, 3);
    chk(stk_q.size() == 0, "R5 jumpi pops two", stk_q.size(), 0);

    // R5: not taken, even with an invalid target
    code_q = '{8'h57, 8'h00, 8'h5B, 8'h00};
    stk_q = '{32'd1, 32'd0}; exp_q = '{0, 1};
    run("jumpi not taken", 1'b1, 1'b0, 1);

    // R5: backward loop to address 0, then falls through
    code_q = '{8'h5B, 8'h57, 8'h00};
    stk_q = '{32'd0, 32'd1, 32'd0, 32'd0}; exp_q = '{0, 1, 0, 1, 2};
    run("jumpi loop", 1'b1, 1'b0, 2);

    // R6: target is a marker inside push data
    code_q = '{8'h56, 8'h60, 8'h5B, 8'h5B, 8'h00};
    stk_q = '{32'd2}; exp_q = '{0};
    run("into push data", 1'b0, 1'b1, 0);

    // R6: same program, target is the real marker
    code_q = '{8'h56, 8'h60, 8'h5B, 8'h5B, 8'h00};
    stk_q = '{32'd3}; exp_q = '{0, 3, 4};
    run("real marker", 1'b1, 1'b0, 4);

    // R6: target on a non-marker opcode
    code_q = '{8'h01, 8'h56, 8'h5B, 8'h00};
    stk_q = '{32'd3}; exp_q = '{0, 1};
    run("non-marker target", 1'b0, 1'b1, 1);

    // R7: target equal to code length
    code_q = '{8'h56, 8'h01, 8'h5B, 8'h00};
    stk_q = '{32'd4}; exp_q = '{0};
    run("target at end", 1'b0, 1'b1, 0);

    // R7: high bits set, low bits point at a marker
    code_q = '{8'h56, 8'h01, 8'h5B, 8'h00};
    stk_q = '{32'h8000_0002}; exp_q = '{0};
    run("target high bits", 1'b0, 1'b1, 0);

    // R7: taken jumpi to a target past the end
    code_q = '{8'h57, 8'h5B, 8'h00};
    stk_q = '{32'd200, 32'd1}; exp_q = '{0};
    run("jumpi past end", 1'b0, 1'b1, 0);

    // R8: run off the end without stop opcode
    code_q = '{8'h01, 8'h01};
    stk_q = {}; exp_q = '{0, 1};
    run("off end", 1'b1, 1'b0, 2);

    // R8: push running past the end clamps to code length
    code_q = '{8'h01, 8'h62, 8'hAA};
    stk_q = {}; exp_q = '{0, 1};
    run("push past end", 1'b1, 1'b0, 3);

    // R10: delayed acknowledges hold the sequencer
    ack_dly = 3; stall_cnt = 0;
    code_q = '{8'h57, 8'h00, 8'h5B, 8'h00};
    stk_q = '{32'd2, 32'd7}; exp_q = '{0, 2, 3};
    run("pop stall", 1'b1, 1'b0, 3);
    chk(stall_cnt >= 6, "R10 stalled pop cycles", stall_cnt, 6);
    ack_dly = 0;

    summary();
    $finish;
  end

endmodule